// File: doc/BRIEF.md
# Link Halt Guard

The guard sits between one serial link's flit interface and the local router and protects both sides from untrustworthy traffic. On the receive side it comes out of reset refusing every incoming flit. It accepts traffic only after an external release, which is given once every chip in the processing chain has been configured. It holds each arriving packet until the packet's tail has been checked. A packet is forwarded only if none of its flits carried an uncorrectable error, its end-of-packet CRC passed, and it fit in the buffer. Otherwise the whole packet is silently dropped. Nothing is retransmitted, and there is no buffering at the source.

A flit marked as a halt message from the neighbour puts the receiver back into the discarding state. Any half-received packet is thrown away. Leaving that state takes a link re-establish indication first and then a fresh release. On the transmit side every outgoing flit passes through a fixed delay line. A link-down indication wipes everything still in that line, so flits already sent toward a failing link never reach it. Before local reconfiguration, a halt request places one halt flit into the line and mutes further data until the link is re-established. The single-bit-correct, double-bit-detect codec and the CRC engine are outside the block and appear only as status flags on each received flit.

Top module: `link_halt_guard`

## Requirements
- R1: After reset `rxHalted` is 1, and every flit offered on the receive side is discarded with nothing delivered until `rxRelease` is pulsed.
- R2: Once released, a packet whose flits are all clean is delivered in order with `rxOutLast` on its final flit. Delivery runs one flit per cycle and starts in the cycle after its tail flit was accepted.
- R3: If any flit of a packet has `rxInUncorr` = 1, none of that packet's flits is delivered. Later packets are unaffected.
- R4: A packet whose tail flit has `rxInCrcBad` = 1 is dropped entirely. `rxInCrcBad` is looked at only on a flit with `rxInLast` = 1.
- R5: A packet that arrives while the buffer already holds `BUF_DEPTH` flits is dropped entirely. This covers packets longer than `BUF_DEPTH`. A packet of exactly `BUF_DEPTH` flits reaching an empty buffer is delivered.
- R6: A received flit with `rxInHaltMsg` = 1 drops any partly received packet and returns the receiver to the discarding state (`rxHalted` = 1). In that state `rxRelease` has no effect until `linkReestablish` has been seen, and the next `rxRelease` after that resumes reception.
- R7: A data flit offered with `txInValid` = 1 appears on `txOut*` exactly `TX_DELAY` cycles later, with its data and last bit unchanged and `txOutHalt` = 0.
- R8: In a cycle with `linkDown` = 1, every flit still inside the transmit delay line and the flit offered that cycle are discarded and never appear on `txOut*`.
- R9: `txHaltReq` emits one halt flit `TX_DELAY` cycles later: `txOutHalt` = 1, `txOutLast` = 1, `txOutData` = `HALT_CODE`. Any data flit offered in the same cycle is discarded. Data flits are then discarded until `linkReestablish` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txInValid | input | 1 | Router offers a flit for transmission |
| txInData | input | DATA_W | Outgoing flit payload |
| txInLast | input | 1 | Outgoing flit ends its packet |
| txHaltReq | input | 1 | Send a halt message ahead of local reconfiguration |
| linkDown | input | 1 | Link failure detected this cycle |
| linkReestablish | input | 1 | Link has been brought back up |
| txOutValid | output | 1 | Flit toward the serializer is valid |
| txOutData | output | DATA_W | Flit payload toward the serializer |
| txOutLast | output | 1 | Flit ends its packet |
| txOutHalt | output | 1 | Flit is a halt message |
| rxInValid | input | 1 | Flit received from the link |
| rxInData | input | DATA_W | Received flit payload |
| rxInLast | input | 1 | Received flit ends its packet |
| rxInHaltMsg | input | 1 | Received flit is the neighbour's halt message |
| rxInUncorr | input | 1 | Codec found an uncorrectable error in this flit |
| rxInCrcBad | input | 1 | Packet CRC failed (valid with rxInLast) |
| rxRelease | input | 1 | External command to leave the discarding state |
| rxOutValid | output | 1 | Checked flit delivered to the router |
| rxOutData | output | DATA_W | Delivered flit payload |
| rxOutLast | output | 1 | Delivered flit ends its packet |
| rxHalted | output | 1 | Receiver is discarding incoming traffic |

## Verification
The bench builds the guard with `DATA_W` = 16, `BUF_DEPTH` = 4 and `TX_DELAY` = 4. The shallow buffer brings the overflow drop of R5 within reach with five-flit packets. It also shows the exact-fit case with four flits, and a second packet that is written while the first is still draining. The four-stage delay line lets a link failure land while several flits are in flight, and lets a halt request coincide with a data flit.

// File: rtl/link_halt_guard_pkg.sv
package link_halt_guard_pkg;

  // Receive-side operating modes
  typedef enum logic [1:0] {
    RX_HOLD_INIT     = 2'd0,  // out of reset, waiting for the first release
    RX_RUN           = 2'd1,  // accepting traffic
    RX_PEER_HALT     = 2'd2,  // neighbour halted, waiting for re-establish
    RX_AWAIT_RELEASE = 2'd3   // link back up, waiting for release
  } rxMode_e;

  // Strobes from the control to the two datapaths
  typedef struct packed {
    logic rxAccept;   // current rx flit enters the packet buffer
    logic rxAbort;    // discard the partly received packet
    logic txInject;   // place a halt flit into the delay line
    logic txPass;     // place the offered data flit into the delay line
    logic txFlush;    // wipe the delay line
  } guardStrobe_t;

endpackage

// File: rtl/link_halt_guard_ctrl.sv
module link_halt_guard_ctrl
  import link_halt_guard_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         rxInValid,
  input  logic         rxInHaltMsg,
  input  logic         rxRelease,
  input  logic         linkReestablish,
  input  logic         txInValid,
  input  logic         txHaltReq,
  input  logic         linkDown,
  output guardStrobe_t strb,
  output logic         rxHalted
);

  rxMode_e rxMode, rxModeNext;
  logic    txMuted;
  logic    peerHaltSeen;

  assign peerHaltSeen = rxInValid && rxInHaltMsg;

  always_comb begin
    rxModeNext = rxMode;
    unique case (rxMode)
      RX_HOLD_INIT:     if (rxRelease) rxModeNext = RX_RUN;
      RX_RUN:           if (peerHaltSeen) rxModeNext = RX_PEER_HALT;
      RX_PEER_HALT:     if (linkReestablish) rxModeNext = RX_AWAIT_RELEASE;
      RX_AWAIT_RELEASE: begin
        if (peerHaltSeen)   rxModeNext = RX_PEER_HALT;
        else if (rxRelease) rxModeNext = RX_RUN;
      end
      default:          rxModeNext = RX_HOLD_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMode  <= RX_HOLD_INIT;
      txMuted <= 1'b0;
    end else begin
      rxMode <= rxModeNext;
      if (txHaltReq)            txMuted <= 1'b1;
      else if (linkReestablish) txMuted <= 1'b0;
    end
  end

  always_comb begin
    strb.rxAccept = (rxMode == RX_RUN) && rxInValid && !rxInHaltMsg;
    strb.rxAbort  = (rxMode != RX_RUN) || peerHaltSeen;
    strb.txInject = txHaltReq;
    strb.txPass   = txInValid && !txMuted && !txHaltReq;
    strb.txFlush  = linkDown;
  end

  assign rxHalted = (rxMode != RX_RUN);

  // A halt message seen while running always stops reception
  assert_peer_halt_R6: assert property (@(posedge clk) disable iff (!rstN)
    (peerHaltSeen && rxMode == RX_RUN) |=> (rxMode == RX_PEER_HALT));

  // Release cannot bypass the re-establish step
  assert_release_blocked_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rxMode == RX_PEER_HALT) |=> (rxMode != RX_RUN));

  // After a halt request no data flit may enter on the next cycle
  assert_mute_after_halt_R9: assert property (@(posedge clk) disable iff (!rstN)
    txHaltReq |=> !strb.txPass);

endmodule

// File: rtl/link_halt_guard_rxbuf.sv
module link_halt_guard_rxbuf
  import link_halt_guard_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BUF_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  guardStrobe_t      strb,
  input  logic [DATA_W-1:0] inData,
  input  logic              inLast,
  input  logic              inUncorr,
  input  logic              inCrcBad,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outLast
);

  localparam int AW = $clog2(BUF_DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULL_COUNT = PW'(BUF_DEPTH);

  logic [DATA_W-1:0] memData [BUF_DEPTH];
  logic              memLast [BUF_DEPTH];

  logic [PW-1:0] wrPtr, cmPtr, rdPtr, occupancy;
  logic          pktBad, bufFull, flitBad, doWrite, doRead;

  assign occupancy = wrPtr - rdPtr;
  assign bufFull   = (occupancy == FULL_COUNT);
  assign flitBad   = pktBad || inUncorr || bufFull || (inLast && inCrcBad);
  assign doWrite   = strb.rxAccept && !bufFull;
  assign doRead    = (rdPtr != cmPtr);

  always_ff @(posedge clk) begin
    if (doWrite) begin
      memData[wrPtr[AW-1:0]] <= inData;
      memLast[wrPtr[AW-1:0]] <= inLast;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      cmPtr  <= '0;
      rdPtr  <= '0;
      pktBad <= 1'b0;
    end else begin
      if (doRead) rdPtr <= rdPtr + 1'b1;
      if (strb.rxAbort) begin
        wrPtr  <= cmPtr;
        pktBad <= 1'b0;
      end else if (strb.rxAccept) begin
        if (inLast) begin
          pktBad <= 1'b0;
          if (flitBad) begin
            wrPtr <= cmPtr;
          end else begin
            wrPtr <= wrPtr + 1'b1;
            cmPtr <= wrPtr + 1'b1;
          end
        end else begin
          pktBad <= flitBad;
          if (doWrite) wrPtr <= wrPtr + 1'b1;
        end
      end
    end
  end

  assign outValid = doRead;
  assign outData  = memData[rdPtr[AW-1:0]];
  assign outLast  = memLast[rdPtr[AW-1:0]];

  // The buffer never holds more than its depth
  assert_no_overrun_R5: assert property (@(posedge clk) disable iff (!rstN)
    occupancy <= FULL_COUNT);

  // The committed boundary moves only on an accepted tail flit
  assert_commit_on_tail_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.rxAccept && inLast) |=> (cmPtr == $past(cmPtr)));

  // Control never asks to keep and discard a flit at once
  assert_accept_excl_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.rxAccept |-> !strb.rxAbort);

endmodule

// File: rtl/link_halt_guard_txdelay.sv
module link_halt_guard_txdelay
  import link_halt_guard_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter int                TX_DELAY  = 4,
  parameter logic [DATA_W-1:0] HALT_CODE = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  guardStrobe_t      strb,
  input  logic [DATA_W-1:0] inData,
  input  logic              inLast,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outLast,
  output logic              outHalt
);

  localparam int TOP = TX_DELAY - 1;

  logic              stV [TX_DELAY];
  logic [DATA_W-1:0] stD [TX_DELAY];
  logic              stL [TX_DELAY];
  logic              stH [TX_DELAY];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stV[0] <= 1'b0;
      stD[0] <= '0;
      stL[0] <= 1'b0;
      stH[0] <= 1'b0;
    end else begin
      stV[0] <= !strb.txFlush && (strb.txInject || strb.txPass);
      stD[0] <= strb.txInject ? HALT_CODE : inData;
      stL[0] <= strb.txInject || inLast;
      stH[0] <= strb.txInject;
    end
  end

  for (genvar s = 1; s < TX_DELAY; s++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stV[s] <= 1'b0;
        stD[s] <= '0;
        stL[s] <= 1'b0;
        stH[s] <= 1'b0;
      end else begin
        stV[s] <= !strb.txFlush && stV[s-1];
        stD[s] <= stD[s-1];
        stL[s] <= stL[s-1];
        stH[s] <= stH[s-1];
      end
    end
  end

  assign outValid = stV[TOP];
  assign outData  = stD[TOP];
  assign outLast  = stL[TOP];
  assign outHalt  = stV[TOP] && stH[TOP];

  // A link failure leaves nothing on the output next cycle
  assert_flush_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.txFlush |=> !outValid);

  // A halt flit is always a valid, single-flit packet
  assert_halt_shape_R9: assert property (@(posedge clk) disable iff (!rstN)
    outHalt |-> (outValid && outLast));

endmodule

// File: rtl/link_halt_guard.sv
module link_halt_guard
  import link_halt_guard_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter int                BUF_DEPTH = 8,
  parameter int                TX_DELAY  = 4,
  parameter logic [DATA_W-1:0] HALT_CODE = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txInValid,
  input  logic [DATA_W-1:0] txInData,
  input  logic              txInLast,
  input  logic              txHaltReq,
  input  logic              linkDown,
  input  logic              linkReestablish,
  output logic              txOutValid,
  output logic [DATA_W-1:0] txOutData,
  output logic              txOutLast,
  output logic              txOutHalt,
  input  logic              rxInValid,
  input  logic [DATA_W-1:0] rxInData,
  input  logic              rxInLast,
  input  logic              rxInHaltMsg,
  input  logic              rxInUncorr,
  input  logic              rxInCrcBad,
  input  logic              rxRelease,
  output logic              rxOutValid,
  output logic [DATA_W-1:0] rxOutData,
  output logic              rxOutLast,
  output logic              rxHalted
);

  guardStrobe_t strb;

  link_halt_guard_ctrl ctrl_i (
    .clk            (clk),
    .rstN           (rstN),
    .rxInValid      (rxInValid),
    .rxInHaltMsg    (rxInHaltMsg),
    .rxRelease      (rxRelease),
    .linkReestablish(linkReestablish),
    .txInValid      (txInValid),
    .txHaltReq      (txHaltReq),
    .linkDown       (linkDown),
    .strb           (strb),
    .rxHalted       (rxHalted)
  );

  link_halt_guard_rxbuf #(
    .DATA_W   (DATA_W),
    .BUF_DEPTH(BUF_DEPTH)
  ) rxbuf_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .inData  (rxInData),
    .inLast  (rxInLast),
    .inUncorr(rxInUncorr),
    .inCrcBad(rxInCrcBad),
    .outValid(rxOutValid),
    .outData (rxOutData),
    .outLast (rxOutLast)
  );

  link_halt_guard_txdelay #(
    .DATA_W   (DATA_W),
    .TX_DELAY (TX_DELAY),
    .HALT_CODE(HALT_CODE)
  ) txdelay_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .inData  (txInData),
    .inLast  (txInLast),
    .outValid(txOutValid),
    .outData (txOutData),
    .outLast (txOutLast),
    .outHalt (txOutHalt)
  );

endmodule

// File: tb/link_halt_guard_tb.sv
module link_halt_guard_tb_top;

  localparam int DW = 16;
  localparam int DEPTH = 4;
  localparam int DLY = 4;
  localparam logic [DW-1:0] HCODE = 16'hA55A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic          txInValid = 0, txInLast = 0, txHaltReq = 0, linkDown = 0, linkReestablish = 0;
  logic [DW-1:0] txInData = '0;
  logic          txOutValid, txOutLast, txOutHalt;
  logic [DW-1:0] txOutData;
  logic          rxInValid = 0, rxInLast = 0, rxInHaltMsg = 0, rxInUncorr = 0, rxInCrcBad = 0, rxRelease = 0;
  logic [DW-1:0] rxInData = '0;
  logic          rxOutValid, rxOutLast, rxHalted;
  logic [DW-1:0] rxOutData;

  link_halt_guard #(.DATA_W(DW), .BUF_DEPTH(DEPTH), .TX_DELAY(DLY), .HALT_CODE(HCODE)) dut_i (
    .clk(clk), .rstN(rstN),
    .txInValid(txInValid), .txInData(txInData), .txInLast(txInLast),
    .txHaltReq(txHaltReq), .linkDown(linkDown), .linkReestablish(linkReestablish),
    .txOutValid(txOutValid), .txOutData(txOutData), .txOutLast(txOutLast), .txOutHalt(txOutHalt),
    .rxInValid(rxInValid), .rxInData(rxInData), .rxInLast(rxInLast), .rxInHaltMsg(rxInHaltMsg),
    .rxInUncorr(rxInUncorr), .rxInCrcBad(rxInCrcBad), .rxRelease(rxRelease),
    .rxOutValid(rxOutValid), .rxOutData(rxOutData), .rxOutLast(rxOutLast), .rxHalted(rxHalted)
  );

  int    checks = 0;
  int    fails = 0;
  string curReq = "R1";
  int    rxSeen = 0, txSeen = 0, txHaltSeen = 0;

  // ---------------- reference model ----------------
  int            mRxMode;          // 0 hold, 1 run, 2 peer halt, 3 await release
  logic [DW:0]   pend[$];
  logic [DW:0]   commitQ[$];
  logic          pendBad;
  logic          mTxMuted;
  logic          mV[DLY];
  logic [DW-1:0] mD[DLY];
  logic          mL[DLY];
  logic          mH[DLY];

  always @(posedge clk) begin
    if (!rstN) begin
      mRxMode = 0; pend.delete(); commitQ.delete(); pendBad = 0; mTxMuted = 0;
      for (int i = 0; i < DLY; i++) begin mV[i] = 0; mD[i] = '0; mL[i] = 0; mH[i] = 0; end
    end else begin
      bit peerHalt, abortNow, acceptNow, full, bad;
      bit passNow;
      peerHalt  = rxInValid && rxInHaltMsg;
      abortNow  = (mRxMode != 1) || peerHalt;
      acceptNow = (mRxMode == 1) && rxInValid && !rxInHaltMsg;
      full      = (commitQ.size() + pend.size()) == DEPTH;
      if (commitQ.size() > 0) void'(commitQ.pop_front());
      if (abortNow) begin
        pend.delete(); pendBad = 0;
      end else if (acceptNow) begin
        bad = pendBad || rxInUncorr || full || (rxInLast && rxInCrcBad);
        if (!full) pend.push_back({rxInLast, rxInData});
        if (rxInLast) begin
          if (!bad) foreach (pend[k]) commitQ.push_back(pend[k]);
          pend.delete(); pendBad = 0;
        end else pendBad = bad;
      end
      case (mRxMode)
        0: if (rxRelease) mRxMode = 1;
        1: if (peerHalt) mRxMode = 2;
        2: if (linkReestablish) mRxMode = 3;
        default: if (peerHalt) mRxMode = 2; else if (rxRelease) mRxMode = 1;
      endcase
      // transmit
      passNow = txInValid && !mTxMuted && !txHaltReq;
      if (linkDown) begin
        for (int i = 0; i < DLY; i++) mV[i] = 0;
      end else begin
        for (int i = DLY - 1; i > 0; i--) begin
          mV[i] = mV[i-1]; mD[i] = mD[i-1]; mL[i] = mL[i-1]; mH[i] = mH[i-1];
        end
        mV[0] = txHaltReq || passNow;
        mD[0] = txHaltReq ? HCODE : txInData;
        mL[0] = txHaltReq || txInLast;
        mH[0] = txHaltReq;
      end
      if (txHaltReq) mTxMuted = 1;
      else if (linkReestablish) mTxMuted = 0;
    end
  end

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", curReq, what, act, exp);
    end
  endtask

  task automatic compareAll();
    bit eRx = commitQ.size() > 0;
    check(rxHalted == (mRxMode != 1), "rxHalted", 32'(rxHalted), 32'(mRxMode != 1));
    check(rxOutValid == eRx, "rxOutValid", 32'(rxOutValid), 32'(eRx));
    if (eRx && rxOutValid)
      check({rxOutLast, rxOutData} == commitQ[0], "rx flit", 32'({rxOutLast, rxOutData}), 32'(commitQ[0]));
    check(txOutValid == mV[DLY-1], "txOutValid", 32'(txOutValid), 32'(mV[DLY-1]));
    if (mV[DLY-1] && txOutValid)
      check({txOutHalt, txOutLast, txOutData} == {mH[DLY-1], mL[DLY-1], mD[DLY-1]}, "tx flit",
            32'({txOutHalt, txOutLast, txOutData}), 32'({mH[DLY-1], mL[DLY-1], mD[DLY-1]}));
    if (rxOutValid) rxSeen++;
    if (txOutValid) txSeen++;
    if (txOutHalt) txHaltSeen++;
  endtask

  task automatic cyc();
    @(negedge clk);
    if (rstN) compareAll();
    txInValid = 0; txHaltReq = 0; linkDown = 0; linkReestablish = 0;
    rxInValid = 0; rxInHaltMsg = 0; rxInUncorr = 0; rxInCrcBad = 0; rxRelease = 0;
    rxInLast = 0; txInLast = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic rxFlit(input logic [DW-1:0] d, input bit last, input bit unc, input bit crc, input bit hmsg);
    rxInValid = 1; rxInData = d; rxInLast = last; rxInUncorr = unc; rxInCrcBad = crc; rxInHaltMsg = hmsg;
    cyc();
  endtask

  task automatic rxPkt(input int len, input logic [DW-1:0] base);
    for (int i = 0; i < len; i++) rxFlit(base + DW'(i), i == len - 1, 0, 0, 0);
  endtask

  task automatic txFlit(input logic [DW-1:0] d, input bit last);
    txInValid = 1; txInData = d; txInLast = last;
    cyc();
  endtask

  task automatic expectCount(input int act, input int exp, input string what);
    check(act == exp, what, 32'(act), 32'(exp));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1;
    // R1: reset state and discard before release
    curReq = "R1"; rxSeen = 0;
    cyc();
    check(rxHalted == 1'b1, "rxHalted after reset", 32'(rxHalted), 32'd1);
    rxPkt(3, 16'h0100);
    idle(6);
    expectCount(rxSeen, 0, "flits delivered before release");

    // R2: release then clean packets back to back
    curReq = "R2"; rxRelease = 1; cyc(); rxSeen = 0;
    rxPkt(3, 16'h0200); rxPkt(2, 16'h0210);
    idle(8);
    expectCount(rxSeen, 5, "clean flits delivered");

    // R3: uncorrectable error on a middle flit
    curReq = "R3"; rxSeen = 0;
    rxFlit(16'h0300, 0, 0, 0, 0); rxFlit(16'h0301, 0, 1, 0, 0); rxFlit(16'h0302, 1, 0, 0, 0);
    rxPkt(2, 16'h0310);
    idle(6);
    expectCount(rxSeen, 2, "flits after uncorrectable packet");

    // R4: CRC failure on the tail; crc flag ignored off the tail
    curReq = "R4"; rxSeen = 0;
    rxFlit(16'h0400, 0, 0, 0, 0); rxFlit(16'h0401, 0, 0, 0, 0); rxFlit(16'h0402, 1, 0, 1, 0);
    rxFlit(16'h0410, 0, 0, 1, 0); rxFlit(16'h0411, 1, 0, 0, 0);
    idle(6);
    expectCount(rxSeen, 2, "flits after crc drop");

    // R5: overflow drop, then exact fit
    curReq = "R5"; rxSeen = 0;
    rxPkt(5, 16'h0500);
    idle(4);
    expectCount(rxSeen, 0, "oversize packet flits");
    rxPkt(4, 16'h0510);
    idle(8);
    expectCount(rxSeen, 4, "exact fit packet flits");

    // R6: neighbour halt mid packet
    curReq = "R6"; rxSeen = 0;
    rxFlit(16'h0600, 0, 0, 0, 0); rxFlit(16'h0601, 0, 0, 0, 0);
    rxFlit(16'h06FF, 1, 0, 0, 1);
    check(rxHalted == 1'b1, "halted after halt message", 32'(rxHalted), 32'd1);
    rxRelease = 1; cyc();
    check(rxHalted == 1'b1, "release ignored before re-establish", 32'(rxHalted), 32'd1);
    rxPkt(2, 16'h0620);
    linkReestablish = 1; cyc();
    rxPkt(2, 16'h0630);
    idle(4);
    expectCount(rxSeen, 0, "flits delivered while halted");
    rxRelease = 1; cyc();
    rxPkt(2, 16'h0640);
    idle(6);
    expectCount(rxSeen, 2, "flits after resume");

    // R7: transmit delay
    curReq = "R7"; txSeen = 0;
    txFlit(16'h0700, 0); txFlit(16'h0701, 1); cyc(); txFlit(16'h0702, 0); txFlit(16'h0703, 0); txFlit(16'h0704, 1);
    idle(8);
    expectCount(txSeen, 5, "tx flits out");

    // R8: link failure with flits in flight
    curReq = "R8"; txSeen = 0;
    for (int i = 0; i < 5; i++) txFlit(16'h0800 + DW'(i), 0);
    linkDown = 1; txFlit(16'h0805, 1);
    idle(8);
    expectCount(txSeen, 2, "tx flits surviving link down");

    // R9: halt request, mute, re-establish
    curReq = "R9"; txSeen = 0; txHaltSeen = 0;
    txHaltReq = 1; txFlit(16'h0900, 1);
    txFlit(16'h0901, 0); txFlit(16'h0902, 1); txFlit(16'h0903, 1);
    linkReestablish = 1; cyc();
    txFlit(16'h0910, 0); txFlit(16'h0911, 1);
    idle(8);
    expectCount(txHaltSeen, 1, "halt flits out");
    expectCount(txSeen, 3, "tx flits out around halt");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule